// File: doc/BRIEF.md
# Header-Driven Packet Receiver

This block takes a stream of 16-bit words, one per clock when the valid strobe is high. It sits idle until a word flagged as a header arrives. The low byte of that header gives the number of payload words that follow. Each payload word goes out on a write port into a packet buffer, and the block folds it into a running XOR checksum. The buffer address is formed from the current packet slot and a word counter that counts down from the payload size.

After the last payload word, the next word is a trailer. The block compares the trailer with the accumulated checksum:

- On a match, the packet slot index moves to the next slot, modulo 16.
- On a mismatch, an error strobe goes high and the slot index stays where it is, so the next packet overwrites the slot that was just filled.

The buffer storage itself lies outside the block. Only its write port is driven here.

Top module: `pkt_rx_fsm`

## Requirements
- R1: While reset is high and on the cycle after it is released, wr_en and csum_err are 0 and pkt_idx is 0. The block is idle, waiting for a header.
- R2: While idle, a valid word with in_hdr=1 clears the checksum, loads the word counter from in_word[7:0] and starts payload reception. A valid word with in_hdr=0 while idle writes nothing and leaves the block idle.
- R3: Each valid payload word is presented on wr_data with wr_addr = {pkt_idx[3:0], count[7:0]}, in the same cycle the word is on in_word. The count is the value before the word is taken. It runs from the header size down to 1.
- R4: Once the number of payload words given by the header has been taken, the next valid word is the trailer. During payload reception in_hdr is ignored, and a word flagged as a header is stored as payload.
- R5: A valid trailer equal to the XOR of all payload words of the packet increments pkt_idx at the following clock edge. The block then returns to idle.
- R6: A valid trailer that differs from the checksum drives csum_err to 1 for that cycle only. pkt_idx is left unchanged and the block returns to idle, so the next packet is written to the same slot.
- R7: A cycle with in_valid=0 changes no state and produces no write and no error.
- R8: A header with size 0 goes directly to the trailer stage with a checksum of 0. No payload words are written.
- R9: pkt_idx wraps from 15 to 0 on a matching trailer.
- R10: wr_en is 1 only in cycles where a valid payload word is being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word on in_word is present this cycle |
| in_hdr | input | 1 | Word is a header (used only while idle) |
| in_word | input | 16 | Data word; low byte of a header is the payload size |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 12 | Buffer address {slot, word count} |
| wr_data | output | 16 | Buffer write data |
| pkt_idx | output | 4 | Current packet slot index |
| csum_err | output | 1 | Trailer mismatch strobe |

## Verification
The count-decrement assertion assumes the receive state is never entered with a zero count. That holds only because a size-0 header is sent straight to the trailer stage, so the stimulus issues size-0 headers often, both with correct and with corrupted trailers. The assertions also assume the inputs are stable and known around each rising edge. The bench therefore changes inputs only on the falling edge. It inserts random low-valid gaps inside packets, mixes non-header noise in between packets, and sets the header flag on payload words, so that the hold and ignore properties are exercised.

// File: rtl/pkt_rx_fsm.sv
module pkt_rx_fsm #(
  parameter int W     = 16,
  parameter int CNT_W = 8,
  parameter int PKT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_hdr,
  input  logic [W-1:0]           in_word,
  output logic                   wr_en,
  output logic [PKT_W+CNT_W-1:0] wr_addr,
  output logic [W-1:0]           wr_data,
  output logic [PKT_W-1:0]       pkt_idx,
  output logic                   csum_err
);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_CHK} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     csum;
  logic [PKT_W-1:0] pkt;

  wire [CNT_W-1:0] hdr_len = in_word[CNT_W-1:0];
  wire [CNT_W-1:0] cnt_dec = cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      csum <= '0;
      pkt  <= '0;
    end else if (in_valid) begin
      case (st)
        S_IDLE: if (in_hdr) begin
          cnt  <= hdr_len;
          csum <= '0;
          st   <= (hdr_len == '0) ? S_CHK : S_RECV;
        end
        S_RECV: begin
          csum <= csum ^ in_word;
          cnt  <= cnt_dec;
          if (cnt_dec == '0) st <= S_CHK;
        end
        S_CHK: begin
          if (in_word == csum) pkt <= pkt + 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr_en    = in_valid && (st == S_RECV);
  assign wr_addr  = {pkt, cnt};
  assign wr_data  = in_word;
  assign pkt_idx  = pkt;
  assign csum_err = in_valid && (st == S_CHK) && (in_word != csum);

  p_hdr_start_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && in_valid && in_hdr) |=> (st != S_IDLE && csum == '0));

  p_zero_len_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && in_valid && in_hdr && hdr_len == '0) |=> (st == S_CHK));

  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_RECV && in_valid) |=> (cnt == $past(cnt) - 1'b1));

  p_last_word_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_RECV && in_valid && cnt == 1) |=> (st == S_CHK));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(st) && $stable(cnt) && $stable(csum) && $stable(pkt)));

  p_pkt_only_chk_r5: assert property (@(posedge clk) disable iff (rst)
    !(st == S_CHK && in_valid) |=> $stable(pkt));

  p_err_keeps_slot_r6: assert property (@(posedge clk) disable iff (rst)
    csum_err |=> ($stable(pkt) && st == S_IDLE && !csum_err));

endmodule

// File: tb/test_pkt_rx_fsm.sv
module test_pkt_rx_fsm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_hdr = 1'b0;
  logic [15:0] in_word = '0;
  logic        wr_en;
  logic [11:0] wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  pkt_idx;
  logic        csum_err;

  int checks = 0;
  int errors = 0;

  // expected state: 0 idle, 1 receive, 2 trailer
  int        m_st = 0;
  bit [7:0]  m_cnt = 0;
  bit [15:0] m_cs = 0;
  bit [3:0]  m_pkt = 0;

  always #2 clk = ~clk;

  pkt_rx_fsm i_pkt_rx_fsm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hdr(in_hdr), .in_word(in_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pkt_idx(pkt_idx),
    .csum_err(csum_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [15:0] fold(input bit [15:0] acc, input bit [15:0] w);
    return acc ^ w;
  endfunction

  task automatic step(input string tag, input bit v, input bit h, input bit [15:0] w);
    bit ewe, eerr;
    @(negedge clk);
    in_valid = v; in_hdr = h; in_word = w;
    #1;
    ewe  = v && m_st == 1;
    eerr = v && m_st == 2 && w != m_cs;
    chk(tag, "R10 wr_en", wr_en, ewe);
    if (ewe) begin
      chk(tag, "R3 wr_addr", wr_addr, {m_pkt, m_cnt});
      chk(tag, "R3 wr_data", wr_data, w);
    end
    chk(tag, "R6 csum_err", csum_err, eerr);
    chk(tag, "R5 pkt_idx", pkt_idx, m_pkt);
    if (v) begin
      case (m_st)
        0: if (h) begin
          m_cnt = w[7:0]; m_cs = 0; m_st = (w[7:0] == 0) ? 2 : 1;
        end
        1: begin
          m_cs = fold(m_cs, w); m_cnt = m_cnt - 1; if (m_cnt == 0) m_st = 2;
        end
        default: begin
          if (w == m_cs) m_pkt = m_pkt + 1;
          m_st = 0;
        end
      endcase
    end
  endtask

  task automatic send_pkt(input string tag, input int size, input bit bad,
                          input bit hdr_in_pay, input int gap_pct);
    bit [15:0] cs = 0;
    bit [15:0] w;
    step(tag, 1, 1, {8'($urandom), 8'(size)});
    for (int i = 0; i < size; i++) begin
      while (($urandom % 100) < gap_pct) step({tag, " R7"}, 0, 1, 16'($urandom));
      w = 16'($urandom);
      cs = fold(cs, w);
      step(tag, 1, hdr_in_pay, w);
    end
    while (($urandom % 100) < gap_pct) step({tag, " R7"}, 0, 0, 16'($urandom));
    step(tag, 1, 0, bad ? (cs ^ (16'($urandom) | 16'h1)) : cs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [3:0] p0;
    void'($urandom(32'd2468));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "reset wr_en", wr_en, 0);
    chk("R1", "reset csum_err", csum_err, 0);
    chk("R1", "reset pkt_idx", pkt_idx, 0);
    rst = 1'b0;
    step("R1", 0, 0, 0);

    for (int i = 0; i < 5; i++) step("R2 noise", 1, 0, 16'($urandom));
    send_pkt("R2", 3, 0, 0, 0);
    chk("R2", "pkt after good", pkt_idx, 0);
    step("R2", 0, 0, 0);
    chk("R2", "pkt advanced", pkt_idx, 1);

    send_pkt("R4", 4, 0, 1, 0);
    step("R4", 0, 0, 0);
    chk("R4", "pkt after header-flagged payload", pkt_idx, 2);

    p0 = pkt_idx;
    send_pkt("R6", 5, 1, 0, 0);
    step("R6", 0, 0, 0);
    chk("R6", "slot kept after mismatch", pkt_idx, p0);
    send_pkt("R6", 2, 0, 0, 0);

    send_pkt("R7", 6, 0, 0, 60);

    send_pkt("R8", 0, 0, 0, 0);
    step("R8", 0, 0, 0);
    chk("R8", "zero size good", pkt_idx, m_pkt);
    send_pkt("R8", 0, 1, 0, 0);

    for (int i = 0; i < 17; i++) send_pkt("R9", 1 + (i % 3), 0, 0, 0);
    step("R9", 0, 0, 0);
    chk("R9", "wrapped index", pkt_idx, m_pkt);

    for (int n = 0; n < 300; n++) begin
      int nz = $urandom % 3;
      for (int k = 0; k < nz; k++) step("rand idle R2", 1, 0, 16'($urandom));
      send_pkt("rand", ($urandom % 4 == 0) ? 0 : int'($urandom % 20),
               ($urandom % 5) == 0, ($urandom % 4) == 0, 25);
    end
    step("final", 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule